// File: doc/BRIEF.md
# Interrupt Source Routing Register Bank

This block collects a set of level-sensitive interrupt lines and merges them with requests that software raises through registers. A per-source select register sends each source to one of two paths. The normal path is gated by an enable mask. The fast path is not gated and drives a single fast request line. Both per-source status vectors are brought out as ports. The normal vector feeds a separate priority resolver, which is not part of this block.

Software reaches the block through a word-addressed register bus with single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. The enable and software-request registers each have a set address and a clear address, so that one source can change without a read-modify-write. The select register takes a plain write. A one-bit protection flag is kept for a neighbouring access checker. A fixed eight-word identification block sits at the top of the address window.

Top module: `irq_route_bank`

## Requirements
- R1: The raw vector is the bitwise OR of `hw_req` and the software-request register. Bus word 2 reads it back.
- R2: `norm_status` equals raw AND enable AND NOT select. Bus word 0 reads the same value.
- R3: `fast_status` equals raw AND select, with no enable gating. Bus word 1 reads the same value.
- R4: `fast_req` is high exactly when some bit of `fast_status` is set.
- R5: A write to word 4 ORs the data into the enable register. A write to word 5 clears the enable bits where the data is one. Word 4 reads the enable register.
- R6: A write to word 6 ORs the data into the software-request register. A write to word 7 clears the bits where the data is one. Word 6 reads the register.
- R7: A write to word 3 replaces the select register. Word 3 reads it back.
- R8: A write to word 8 stores data bit 0 as the protection flag. Word 8 reads the flag in bit 0, and all other bits read zero.
- R9: A write to word 0 changes no register and no output.
- R10: Reads of words 0x3F8 to 0x3FF return, in bits 7:0 with all upper bits zero, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in that order.
- R11: A read of any word not listed above returns zero. This includes the clear-only words 5 and 7.
- R12: A synchronous active-high reset clears the select, enable, software-request and protection registers and the read data.
- R13: `bus_rdata` takes its new value at the clock edge where `bus_rd` is high and keeps that value until the next read. A register written at a clock edge affects the status ports right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | NSRC | Level interrupt inputs, already synchronous to `clk` |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| norm_status | output | NSRC | Enabled normal-path requests, to the priority resolver |
| fast_status | output | NSRC | Fast-path requests |
| fast_req | output | 1 | Any fast-path request present |

## Verification
The routing function is driven from a table of hardware, select, enable and software patterns. The table has enable-only cases, cases with software requests only, cases where a source has select set and enable clear, and cases where both ends of the vector (bits 0 and 31) are routed to opposite paths. Together these show whether the enable mask wrongly touches the fast path, whether software requests join the raw OR, and whether bits are routed by the wrong index. Directed sequences then accumulate and clear the enable and software registers step by step, write the ignored status address, and read the identification and unmapped words. They also show that read data holds between reads.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Word indices on the register bus (byte offset divided by four)
  localparam int W_NORM    = 0;
  localparam int W_FAST    = 1;
  localparam int W_RAW     = 2;
  localparam int W_SEL     = 3;
  localparam int W_EN_SET  = 4;
  localparam int W_EN_CLR  = 5;
  localparam int W_SW_SET  = 6;
  localparam int W_SW_CLR  = 7;
  localparam int W_PROT    = 8;
  localparam int W_ID_BASE = 'h3F8;

  // Identification byte for each of the eight words at the top of the window
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h90;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
// Register with separate OR-in and clear-where-one update ports
module irq_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  assign set_mask = set_en ? bits : '0;
  assign clr_mask = clr_en ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_mask) & ~clr_mask;
  end

endmodule

// File: rtl/irq_status_merge.sv
// Per-source merge of hardware and software requests and split into two paths
module irq_status_merge #(
  parameter int N = 32
) (
  input  logic [N-1:0] hw,
  input  logic [N-1:0] sw,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] en,
  output logic [N-1:0] raw,
  output logic [N-1:0] norm,
  output logic [N-1:0] fast,
  output logic         any_fast
);

  for (genvar g = 0; g < N; g++) begin : g_src
    assign raw[g]  = hw[g] | sw[g];
    assign norm[g] = raw[g] & en[g] & ~sel[g];
    assign fast[g] = raw[g] & sel[g];
  end

  assign any_fast = |fast;

endmodule

// File: rtl/irq_read_mux.sv
// Combinational read-data selection by word address
module irq_read_mux #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  raw,
  input  logic [N-1:0]  norm,
  input  logic [N-1:0]  fast,
  input  logic [N-1:0]  sel,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  sw,
  input  logic          prot,
  output logic [DW-1:0] rdata
);
  import irq_route_pkg::*;

  always_comb begin
    rdata = '0;
    if (addr >= AW'(W_ID_BASE)) begin
      rdata = DW'(id_byte(addr[2:0]));
    end else begin
      case (addr)
        AW'(W_NORM):   rdata = DW'(norm);
        AW'(W_FAST):   rdata = DW'(fast);
        AW'(W_RAW):    rdata = DW'(raw);
        AW'(W_SEL):    rdata = DW'(sel);
        AW'(W_EN_SET): rdata = DW'(en);
        AW'(W_SW_SET): rdata = DW'(sw);
        AW'(W_PROT):   rdata = DW'(prot);
        default:       rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_req,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NSRC-1:0] norm_status,
  output logic [NSRC-1:0] fast_status,
  output logic            fast_req
);
  import irq_route_pkg::*;

  logic [NSRC-1:0] sel_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] sw_q;
  logic            prot_q;
  logic [NSRC-1:0] raw_v;
  logic [NSRC-1:0] wbits;
  logic [DW-1:0]   rd_next;

  assign wbits = bus_wdata[NSRC-1:0];

  // Plain-write configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      prot_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(W_SEL))  sel_q  <= wbits;
      if (bus_addr == AW'(W_PROT)) prot_q <= bus_wdata[0];
    end
  end

  irq_setclr_reg #(.W(NSRC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .set_en (bus_wr && bus_addr == AW'(W_EN_SET)),
    .clr_en (bus_wr && bus_addr == AW'(W_EN_CLR)),
    .bits   (wbits),
    .q      (en_q)
  );

  irq_setclr_reg #(.W(NSRC)) u_sw (
    .clk    (clk),
    .rst    (rst),
    .set_en (bus_wr && bus_addr == AW'(W_SW_SET)),
    .clr_en (bus_wr && bus_addr == AW'(W_SW_CLR)),
    .bits   (wbits),
    .q      (sw_q)
  );

  irq_status_merge #(.N(NSRC)) u_merge (
    .hw       (hw_req),
    .sw       (sw_q),
    .sel      (sel_q),
    .en       (en_q),
    .raw      (raw_v),
    .norm     (norm_status),
    .fast     (fast_status),
    .any_fast (fast_req)
  );

  irq_read_mux #(.N(NSRC), .DW(DW), .AW(AW)) u_rmux (
    .addr  (bus_addr),
    .raw   (raw_v),
    .norm  (norm_status),
    .fast  (fast_status),
    .sel   (sel_q),
    .en    (en_q),
    .sw    (sw_q),
    .prot  (prot_q),
    .rdata (rd_next)
  );

  // Registered read data, held between reads
  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] hw_req,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NSRC-1:0] norm_status,
  input logic [NSRC-1:0] fast_status,
  input logic            fast_req,
  input logic [NSRC-1:0] sel_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] sw_q,
  input logic            prot_q
);

  assert_norm_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (norm_status & ~en_q) == '0);

  assert_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
    (norm_status & fast_status) == '0);

  assert_fast_hi_R4: assert property (@(posedge clk) disable iff (rst)
    fast_req |-> (((hw_req | sw_q) & sel_q) != '0));

  assert_fast_lo_R4: assert property (@(posedge clk) disable iff (rst)
    !fast_req |-> (((hw_req | sw_q) & sel_q) == '0));

  assert_en_set_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(4)) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  assert_en_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(5)) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

  assert_sw_set_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(6)) |=>
      ((sw_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  assert_sw_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(7)) |=> ((sw_q & $past(bus_wdata[NSRC-1:0])) == '0));

  assert_sel_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(3)) |=> (sel_q == $past(bus_wdata[NSRC-1:0])));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(0)) |=>
      ($stable(sel_q) && $stable(en_q) && $stable(sw_q) && $stable(prot_q)));

  assert_reset_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0 && en_q == '0 && sw_q == '0 && !prot_q && bus_rdata == '0));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_rd) && !$past(rst)) |-> $stable(bus_rdata));

endmodule

bind irq_route_bank irq_route_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_req      (hw_req),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .norm_status (norm_status),
  .fast_status (fast_status),
  .fast_req    (fast_req),
  .sel_q       (sel_q),
  .en_q        (en_q),
  .sw_q        (sw_q),
  .prot_q      (prot_q)
);

// File: tb/sim_irq_route_bank.sv
`timescale 1ns/1ps
module sim_irq_route_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] hw_req;
  logic        bus_wr, bus_rd;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] norm_status, fast_status;
  logic        fast_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_route_bank u0 (
    .clk(clk), .rst(rst), .hw_req(hw_req), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .norm_status(norm_status), .fast_status(fast_status), .fast_req(fast_req)
  );

  // Routing vectors: {hw, select, enable, software}
  localparam logic [127:0] VECS [6] = '{
    {32'h0000_00FF, 32'h0000_0000, 32'h0000_000F, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_F000, 32'h0000_0000, 32'h0000_3000},
    {32'hA5A5_A5A5, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_0001},
    {32'h8000_0001, 32'h8000_0000, 32'h8000_0001, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F},
    {32'hFFFF_FFFF, 32'h5555_5555, 32'h0000_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] ids [8];
    ids = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    rst = 1'b1; hw_req = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 rdata", bus_rdata, 32'h0);
    chk("R12 norm", norm_status, 32'h0);
    chk("R12 fast", {31'h0, fast_req} | fast_status, 32'h0);
    rd(3, d); chk("R12 select", d, 32'h0);
    rd(4, d); chk("R12 enable", d, 32'h0);
    rd(6, d); chk("R12 swreq", d, 32'h0);
    rd(8, d); chk("R12 prot", d, 32'h0);

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      logic [31:0] h, s, e, w, raw, en_exp, ft;
      {h, s, e, w} = VECS[i];
      wr(5, 32'hFFFF_FFFF);
      wr(7, 32'hFFFF_FFFF);
      wr(3, s);
      wr(4, e);
      wr(6, w);
      hw_req = h;
      #1;
      raw = h | w;
      en_exp = raw & e & ~s;
      ft = raw & s;
      chk("R2 norm_status", norm_status, en_exp);
      chk("R3 fast_status", fast_status, ft);
      chk("R4 fast_req", {31'h0, fast_req}, {31'h0, ft != 0});
      rd(0, d); chk("R2 word0", d, en_exp);
      rd(1, d); chk("R3 word1", d, ft);
      rd(2, d); chk("R1 word2", d, raw);
    end

    // R5 enable accumulate and clear
    hw_req = 32'h0000_000F;
    wr(3, 32'h0); wr(5, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    wr(4, 32'h3); wr(4, 32'hC);
    rd(4, d); chk("R5 enable or", d, 32'hF);
    wr(5, 32'h5);
    rd(4, d); chk("R5 enable clear", d, 32'hA);
    #1; chk("R5 norm after clear", norm_status, 32'hA);

    // R6 software request accumulate and clear
    hw_req = 32'h0;
    wr(6, 32'h0001_0000); wr(6, 32'h0000_0002);
    rd(6, d); chk("R6 sw or", d, 32'h0001_0002);
    wr(7, 32'h0001_0000);
    rd(6, d); chk("R6 sw clear", d, 32'h0000_0002);
    rd(2, d); chk("R6 raw via sw", d, 32'h0000_0002);

    // R7 select plain write replaces, R13 status right after write edge
    wr(3, 32'hFFFF_FFF0); wr(3, 32'h0000_0002);
    rd(3, d); chk("R7 select", d, 32'h0000_0002);
    chk("R13 fast after write", fast_status, 32'h0000_0002);

    // R8 protection
    wr(8, 32'hFFFF_FFFF);
    rd(8, d); chk("R8 prot set", d, 32'h1);
    wr(8, 32'h0000_0002);
    rd(8, d); chk("R8 prot bit0 only", d, 32'h0);

    // R9 write to word 0 ignored
    wr(8, 32'h1);
    wr(0, 32'hFFFF_FFFF);
    rd(3, d); chk("R9 select kept", d, 32'h0000_0002);
    rd(4, d); chk("R9 enable kept", d, 32'hA);
    rd(6, d); chk("R9 sw kept", d, 32'h0000_0002);
    rd(8, d); chk("R9 prot kept", d, 32'h1);
    rd(0, d); chk("R9 norm kept", d, 32'h0);

    // R10 identification words
    for (int k = 0; k < 8; k++) begin
      rd('h3F8 + k, d);
      chk("R10 id", d, {24'h0, ids[k]});
    end

    // R11 unmapped words
    rd(5, d);     chk("R11 word5", d, 32'h0);
    rd(7, d);     chk("R11 word7", d, 32'h0);
    rd(9, d);     chk("R11 word9", d, 32'h0);
    rd('h3F7, d); chk("R11 word3F7", d, 32'h0);
    rd('h200, d); chk("R11 word200", d, 32'h0);

    // R13 read data holds without a read strobe
    rd(3, d);
    wr(3, 32'h1234_5678);
    repeat (2) @(negedge clk);
    chk("R13 rdata hold", bus_rdata, 32'h0000_0002);

    // R12 reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    hw_req = 32'h0;
    rd(3, d); chk("R12 sel after reset", d, 32'h0);
    rd(4, d); chk("R12 en after reset", d, 32'h0);
    rd(6, d); chk("R12 sw after reset", d, 32'h0);
    rd(8, d); chk("R12 prot after reset", d, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule